// File: doc/BRIEF.md
# Supply Voltage Monitor Event Controller

This block watches a one-bit comparator input that is already synchronized to `clk`. The input is high while the supply sits at or above a threshold. From it the block derives a monitor status flag, a sticky change-detect flag, a one-cycle interrupt request and a held reset request.

Software sets the control register. It holds two enables for the detector and the monitor, a master event enable, a filter bypass, a mode select (interrupt or reset) and an edge select. Which status transitions count as events depends on three of these controls together. With the filter in use, interrupt mode takes both edges. With the filter bypassed, interrupt mode takes the one edge that the edge select names. Reset mode takes only the falling edge.

The optional noise filter samples the comparator on each `sample_tick`. It accepts a new level only after `FILT_TAPS` consecutive differing samples. Both the filter and the status flag reset to the "above threshold" level, so an unknown input at power-up cannot produce a falling event. None of the signals are data streams, so the block has no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `supply_event_ctrl`

## Requirements
- R1: When control bits det_en (bit 0) and mon_en (bit 1) are both 1, `status` equals the selected comparator level one clock after that level settles.
- R2: When det_en or mon_en is 0, `status` reads 1 whatever the comparator input is.
- R3: `sticky` is cleared only by a `flag_we` write with `flag_wdata` = 0. A write of 1 leaves it unchanged.
- R4: With det_en = 0, no transition sets `sticky`, raises `irq` or raises `rst_req`.
- R5: In interrupt mode with the filter active (filt_off, bit 3, = 0), both a 0→1 and a 1→0 status transition set `sticky`, whatever edge_fall (bit 5) holds.
- R6: In interrupt mode with filt_off = 1, only 0→1 sets `sticky` when edge_fall = 0, and only 1→0 sets it when edge_fall = 1.
- R7: When rst_mode (bit 4) = 1 and evt_en (bit 2) = 1, only a 1→0 transition is an event. It sets `sticky` and `rst_req` and never raises `irq`.
- R8: With evt_en = 0, `irq` and `rst_req` stay low and rst_mode is ignored: edges are qualified as in interrupt mode, and `sticky` still sets.
- R9: `irq` is high for exactly one cycle, in the cycle `sticky` sets. `rst_req` stays high until `rst_ack` is sampled high.
- R10: With the filter active, a comparator change reaches the filtered level on the 4th consecutive `sample_tick` that sees it (`FILT_TAPS` = 4). A shorter run is discarded, and without ticks the level holds.
- R11: Reset clears the control register (`ctrl_rdata` = 0) and leaves `status` = 1, `sticky` = 0, `irq` = 0 and `rst_req` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above | input | 1 | Synchronized comparator: 1 = supply at or above threshold |
| sample_tick | input | 1 | Sampling enable for the noise filter |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control write data {edge_fall, rst_mode, filt_off, evt_en, mon_en, det_en} |
| ctrl_rdata | output | 6 | Control register readback |
| flag_we | input | 1 | Write strobe for the sticky flag |
| flag_wdata | input | 1 | Sticky write data; only 0 acts (clear) |
| rst_ack | input | 1 | Acknowledge that clears `rst_req` |
| status | output | 1 | Monitor status flag |
| sticky | output | 1 | Sticky change-detect flag |
| irq | output | 1 | One-cycle interrupt request |
| rst_req | output | 1 | Held reset request |

## Verification
With the filter bypassed, a comparator change driven before a rising edge shows on `status`, `sticky`, `irq` and `rst_req` after that one edge. With the filter active and `sample_tick` held high, the filter needs four edges and the status register one more, so the results are due on the fifth edge. The bench drives every input on the falling clock edge and steps that exact number of edges before sampling. It checks `irq` again one edge later to confirm the pulse is a single cycle, and confirms that `rst_req` is still held before it pulses `rst_ack`. Control and flag writes take effect on the first edge, so each check waits several settle cycles after a write before it drives the comparator.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int CTRL_W = 6;

  // Bit 0 is det_en ... bit 5 is edge_fall (packed MSB first)
  typedef struct packed {
    logic edge_fall;
    logic rst_mode;
    logic filt_off;
    logic evt_en;
    logic mon_en;
    logic det_en;
  } sem_ctrl_t;
endpackage

// File: rtl/sem_ctrl_regs.sv
module sem_ctrl_regs
  import sem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output sem_ctrl_t         ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= sem_ctrl_t'(ctrl_wdata);
  end

  // R11: the register changes only on a write
  a_r11_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));
endmodule

// File: rtl/sem_noise_filter.sv
module sem_noise_filter #(
  parameter int FILT_TAPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic raw_in,
  output logic level_q
);
  localparam int CNT_W = (FILT_TAPS > 1) ? $clog2(FILT_TAPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_TAPS - 1);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      run_q   <= '0;
    end else if (sample_tick) begin
      if (raw_in == level_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        level_q <= raw_in;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R10: no tick, no change of accepted level
  a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(level_q));
  // R10: a new level is only ever the sampled one
  a_r10_accept_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> ($past(sample_tick) && $past(raw_in) == level_q));
endmodule

// File: rtl/sem_edge_event.sv
module sem_edge_event
  import sem_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sem_ctrl_t ctrl,
  input  logic      src_level,
  input  logic      sticky_clr,
  input  logic      rst_ack,
  output logic      stat_q,
  output logic      sticky_q,
  output logic      irq_q,
  output logic      rst_req_q
);
  logic stat_d, rise, fall, rst_eff, edge_ok, evt;

  always_comb begin
    stat_d  = (ctrl.det_en && ctrl.mon_en) ? src_level : 1'b1;
    rise    = !stat_q && stat_d;
    fall    = stat_q && !stat_d;
    rst_eff = ctrl.evt_en && ctrl.rst_mode;
    if (rst_eff)            edge_ok = fall;
    else if (!ctrl.filt_off) edge_ok = rise || fall;
    else if (ctrl.edge_fall) edge_ok = fall;
    else                    edge_ok = rise;
    evt = ctrl.det_en && edge_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= 1'b1;
      sticky_q  <= 1'b0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (evt)             sticky_q <= 1'b1;
      else if (sticky_clr) sticky_q <= 1'b0;
      irq_q <= evt && ctrl.evt_en && !ctrl.rst_mode;
      if (evt && rst_eff)  rst_req_q <= 1'b1;
      else if (rst_ack)    rst_req_q <= 1'b0;
    end
  end

  // R2: status forced high while monitoring is off
  a_r2_status_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.det_en && ctrl.mon_en) |=> stat_q);
  // R4: sticky rises only with the detector enabled
  a_r4_sticky_needs_det: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_q) |-> $past(ctrl.det_en));
  // R8: no requests without the master enable
  a_r8_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.evt_en |=> !irq_q);
  // R9: irq comes with the sticky flag, for one cycle
  a_r9_irq_with_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> sticky_q);
  // R9: reset request holds until acknowledged
  a_r9_rstreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_q && !rst_ack) |=> rst_req_q);
  // R7: reset request only on a falling status
  a_r7_rstreq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_q) |-> ($past(stat_q) && !stat_q));
endmodule

// File: rtl/supply_event_ctrl.sv
module supply_event_ctrl
  import sem_pkg::*;
#(
  parameter int FILT_TAPS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_above,
  input  logic              sample_tick,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              flag_we,
  input  logic              flag_wdata,
  input  logic              rst_ack,
  output logic              status,
  output logic              sticky,
  output logic              irq,
  output logic              rst_req
);
  sem_ctrl_t ctrl;
  logic      filt_level, src_level, sticky_clr;

  sem_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl)
  );

  sem_noise_filter #(.FILT_TAPS(FILT_TAPS)) u_filt (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .raw_in(cmp_above), .level_q(filt_level)
  );

  assign src_level  = ctrl.filt_off ? cmp_above : filt_level;
  assign sticky_clr = flag_we && !flag_wdata;
  assign ctrl_rdata = ctrl;

  sem_edge_event u_evt (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .src_level(src_level),
    .sticky_clr(sticky_clr), .rst_ack(rst_ack),
    .stat_q(status), .sticky_q(sticky), .irq_q(irq), .rst_req_q(rst_req)
  );

  // R3: only a zero write clears the sticky flag
  a_r3_clear_only_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky) |-> ($past(flag_we) && !$past(flag_wdata)));
endmodule

// File: tb/supply_event_ctrl_tb_top.sv
module supply_event_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_above = 1'b1;
  logic       sample_tick = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic [5:0] ctrl_rdata;
  logic       flag_we = 1'b0;
  logic       flag_wdata = 1'b0;
  logic       rst_ack = 1'b0;
  logic       status, sticky, irq, rst_req;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_event_ctrl #(.FILT_TAPS(TAPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_above(cmp_above), .sample_tick(sample_tick),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .rst_ack(rst_ack),
    .status(status), .sticky(sticky), .irq(irq), .rst_req(rst_req)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // ctrl word {edge_fall, rst_mode, filt_off, evt_en, mon_en, det_en}
  task automatic wr_ctrl(logic ef, logic rm, logic fo, logic ee, logic me, logic de);
    ctrl_wdata = {ef, rm, fo, ee, me, de};
    ctrl_we = 1'b1;
    step();
    ctrl_we = 1'b0;
  endtask

  task automatic clear_all();
    flag_we = 1'b1; flag_wdata = 1'b0; rst_ack = 1'b1;
    step();
    flag_we = 1'b0; rst_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    // R11: state during reset
    chk("R11", "ctrl in reset", ctrl_rdata != 6'd0, 1'b0);
    chk("R11", "status in reset", status, 1'b1);
    chk("R11", "sticky in reset", sticky, 1'b0);
    chk("R11", "irq in reset", irq, 1'b0);
    chk("R11", "rst_req in reset", rst_req, 1'b0);
    rst_n = 1'b1;
    step(2);

    // Sweep: filt_off x rst_mode x edge_fall, evt_en = 1 (R1 R5 R6 R7 R9)
    for (int c = 0; c < 8; c++) begin
      logic fo, rm, ef, exp_f, exp_r;
      int lat;
      fo = c[0]; rm = c[1]; ef = c[2];
      lat = fo ? 1 : TAPS + 1;
      exp_f = rm ? 1'b1 : (fo ? ef : 1'b1);
      exp_r = rm ? 1'b0 : (fo ? !ef : 1'b1);
      cmp_above = 1'b1;
      step(TAPS + 2);
      wr_ctrl(ef, rm, fo, 1'b1, 1'b1, 1'b1);
      step(2);
      clear_all();
      // falling supply
      cmp_above = 1'b0;
      step(lat);
      chk("R1", "status after fall", status, 1'b0);
      chk(rm ? "R7" : (fo ? "R6" : "R5"), "sticky on fall", sticky, exp_f);
      chk("R9", "irq on fall", irq, exp_f && !rm);
      chk("R7", "rst_req on fall", rst_req, exp_f && rm);
      step();
      chk("R9", "irq one cycle", irq, 1'b0);
      chk("R9", "rst_req held", rst_req, exp_f && rm);
      clear_all();
      chk("R9", "rst_req after ack", rst_req, 1'b0);
      chk("R3", "sticky after zero write", sticky, 1'b0);
      // rising supply
      cmp_above = 1'b1;
      step(lat);
      chk("R1", "status after rise", status, 1'b1);
      chk(rm ? "R7" : (fo ? "R6" : "R5"), "sticky on rise", sticky, exp_r);
      chk("R9", "irq on rise", irq, exp_r && !rm);
      chk("R7", "rst_req on rise", rst_req, 1'b0);
      step();
      chk("R9", "irq one cycle rise", irq, 1'b0);
      clear_all();
    end

    // R3: writing 1 leaves sticky alone
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step(2);
    cmp_above = 1'b0; step(2);
    clear_all();
    cmp_above = 1'b1; step();
    chk("R3", "sticky set by rise", sticky, 1'b1);
    flag_we = 1'b1; flag_wdata = 1'b1; step(); flag_we = 1'b0;
    step();
    chk("R3", "sticky after one write", sticky, 1'b1);
    clear_all();
    chk("R3", "sticky after zero write", sticky, 1'b0);

    // R8: master enable off, reset mode ignored
    wr_ctrl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    step(2);
    clear_all();
    cmp_above = 1'b0; step();
    chk("R8", "sticky without evt_en", sticky, 1'b1);
    chk("R8", "irq without evt_en", irq, 1'b0);
    chk("R8", "rst_req without evt_en", rst_req, 1'b0);
    cmp_above = 1'b1; step(2);
    clear_all();

    // R4 / R2: detector disabled
    wr_ctrl(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    step(2);
    cmp_above = 1'b0; step(3);
    chk("R2", "status with det off", status, 1'b1);
    chk("R4", "sticky with det off", sticky, 1'b0);
    chk("R4", "irq with det off", irq, 1'b0);
    cmp_above = 1'b1; step(3);
    chk("R4", "sticky with det off rise", sticky, 1'b0);

    // R10: short glitch rejected, ticks required
    wr_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    step(TAPS + 2);
    clear_all();
    cmp_above = 1'b0; step(TAPS - 1);
    cmp_above = 1'b1; step(TAPS + 2);
    chk("R10", "status after glitch", status, 1'b1);
    chk("R10", "sticky after glitch", sticky, 1'b0);
    sample_tick = 1'b0;
    cmp_above = 1'b0; step(10);
    chk("R10", "status without ticks", status, 1'b1);
    sample_tick = 1'b1; step(TAPS);
    chk("R10", "status one short", status, 1'b1);
    step();
    chk("R10", "status after full run", status, 1'b0);
    chk("R5", "sticky after filtered fall", sticky, 1'b1);

    // R11: reset mid-run clears control
    rst_n = 1'b0; step();
    chk("R11", "ctrl after reset", ctrl_rdata != 6'd0, 1'b0);
    chk("R11", "status after reset", status, 1'b1);
    chk("R11", "sticky after reset", sticky, 1'b0);
    rst_n = 1'b1; step(3);
    chk("R2", "status with mon off after reset", status, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule